// File: doc/BRIEF.md
# PFC Control-Cycle Sequencer

This block orders the work of one digital control period in a power-factor-correction rectifier. A periodic sampling tick (nominally 100 kHz, twice the switching rate, from a 50 MHz clock) starts a pass. The pass first launches all analog channels at once (input voltage, inductor current, output voltage) and waits until every channel has reported. It then launches the outer-loop group together (rectified-sine shaper, RMS feed-forward, DC voltage regulator), waits for all of them, launches the reference multiply/divide stage, launches the inner current regulator, and finally strobes a duty-cycle update into the PWM unit. Each sub-unit is driven by a one-clock start pulse and answers with a one-clock ready pulse. The arithmetic of the sub-units is not part of this block.

Alongside the sequencer sit a start-up timer and a protection latch. After reset, the timer holds the pre-charge resistor in circuit for a programmable number of clocks (100 ms by default) and then closes the bypass. PWM is enabled only on the clock after that. If the measured input current or output voltage rises above its 16-bit limit, the latch trips. The trip forces PWM off until the next reset. A tick that arrives while a pass is still running does not start a new pass and is not queued; it is reported as a one-clock overrun pulse.

Top module: `pfc_cycle_seq`

## Requirements
- R1: While `rst_n` is low, every start strobe, `duty_upd`, `overrun`, `bypass_on`, `pwm_en` and `fault` are 0.
- R2: A tick sampled while the sequencer is idle produces a single one-clock `adc_start` pulse in the following cycle.
- R3: `outer_start` pulses once, in the cycle after the last of the `N_ADC` channel ready pulses has arrived during acquisition. The channels may answer in any order and in any cycles.
- R4: `ref_start` pulses once, in the cycle after the last of the `N_OUTER` outer-loop ready pulses has arrived, in any order.
- R5: `inner_start` follows `ref_ready` by one cycle, and `duty_upd` follows `inner_ready` by one cycle. After that the sequencer is idle again, so a tick sampled in the `duty_upd` cycle is accepted. At most one of the strobes is high in any cycle.
- R6: A ready pulse that arrives while its stage is not being awaited (including while idle) has no effect. No strobe results, and the pulse is not counted toward a later stage.
- R7: A tick sampled while a pass is running gives a one-clock `overrun` pulse in the next cycle, does not start a new pass, and leaves the running pass unchanged.
- R8: After `rst_n` is released, `bypass_on` rises at rising clock edge number `PRECHG_CYC` and stays high. `pwm_en` rises one edge later and never before `bypass_on`.
- R9: `iin_meas` greater than `iin_limit` sets `fault` and clears `pwm_en` at the next edge.
- R10: `vout_meas` greater than `vout_limit` trips in the same way. Equality does not trip.
- R11: Once set, `fault` and the low `pwm_en` persist after the measurement falls back, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| tick | input | 1 | Sampling tick, one clock wide |
| adc_start | output | 1 | Launch all analog channels |
| adc_ready | input | N_ADC | Per-channel conversion-and-transfer complete pulses |
| outer_start | output | 1 | Launch outer-loop group |
| outer_ready | input | N_OUTER | Per-unit outer-loop complete pulses |
| ref_start | output | 1 | Launch current-reference product stage |
| ref_ready | input | 1 | Reference stage complete |
| inner_start | output | 1 | Launch inner current regulator |
| inner_ready | input | 1 | Inner regulator complete |
| duty_upd | output | 1 | Load new duty value into the PWM unit |
| overrun | output | 1 | Tick arrived during a running pass |
| iin_meas | input | DW | Measured input current |
| vout_meas | input | DW | Measured output voltage |
| iin_limit | input | DW | Over-current threshold |
| vout_limit | input | DW | Over-voltage threshold |
| bypass_on | output | 1 | Close pre-charge bypass |
| pwm_en | output | 1 | Allow PWM switching |
| fault | output | 1 | Latched protection trip |

## Verification
The hardest case to reach from the ports is a partially gathered stage. In this case some channel readies have arrived and others have not, and stray readies for a later stage arrive in the same window. If such a stray pulse were counted, the later stage would finish early. The stimulus reaches this case by giving each channel its own ready delay. In one pass it injects outer, reference and inner readies during acquisition, and it then uses long outer delays, so that a wrongly counted early pulse shows up as a strobe in the wrong cycle. A second tick is also placed inside a multi-cycle acquisition. This checks that the overrun pulse appears and that no extra launch occurs.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACQ   = 3'd1,
    ST_OUTER = 3'd2,
    ST_REF   = 3'd3,
    ST_INNER = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pfc_ready_gather.sv
module pfc_ready_gather #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] rdy,
  output logic         done
);
  logic [N-1:0] mask_q, mask_d, seen;

  assign seen = mask_q | rdy;
  assign done = en & (&seen);

  always_comb begin
    mask_d = '0;
    if (en && !done) mask_d = seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // R6: nothing is retained while the stage is not awaited
  a_r6_mask_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (mask_q == '0));
endmodule

// File: rtl/pfc_cycle_fsm.sv
module pfc_cycle_fsm
  import pfc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic adc_done,
  input  logic outer_done,
  input  logic ref_ready,
  input  logic inner_ready,
  output logic in_acq,
  output logic in_outer,
  output logic adc_start,
  output logic outer_start,
  output logic ref_start,
  output logic inner_start,
  output logic duty_upd,
  output logic overrun
);
  seq_state_e state_q, state_d;
  logic [4:0] strb_q, strb_d;
  logic       ovr_q, ovr_d;

  always_comb begin
    state_d = state_q;
    strb_d  = '0;
    ovr_d   = tick && (state_q != ST_IDLE);
    unique case (state_q)
      ST_IDLE:  if (tick)        begin state_d = ST_ACQ;   strb_d[0] = 1'b1; end
      ST_ACQ:   if (adc_done)    begin state_d = ST_OUTER; strb_d[1] = 1'b1; end
      ST_OUTER: if (outer_done)  begin state_d = ST_REF;   strb_d[2] = 1'b1; end
      ST_REF:   if (ref_ready)   begin state_d = ST_INNER; strb_d[3] = 1'b1; end
      ST_INNER: if (inner_ready) begin state_d = ST_IDLE;  strb_d[4] = 1'b1; end
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      strb_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      strb_q  <= strb_d;
      ovr_q   <= ovr_d;
    end
  end

  assign in_acq      = (state_q == ST_ACQ);
  assign in_outer    = (state_q == ST_OUTER);
  assign adc_start   = strb_q[0];
  assign outer_start = strb_q[1];
  assign ref_start   = strb_q[2];
  assign inner_start = strb_q[3];
  assign duty_upd    = strb_q[4];
  assign overrun     = ovr_q;

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adc_start, outer_start, ref_start, inner_start, duty_upd}));
  a_r2_adc_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  a_r7_overrun_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !adc_start);
  a_r3_outer_after_acq: assert property (@(posedge clk) disable iff (!rst_n)
    outer_start |-> $past(in_acq));
endmodule

// File: rtl/pfc_startup.sv
module pfc_startup #(
  parameter int PRECHG_CYC = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic bypass_on
);
  localparam int CW = $clog2(PRECHG_CYC + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          byp_q, byp_d;
  logic          cnt_en;

  assign cnt_en = !byp_q;

  always_comb begin
    cnt_d = cnt_q;
    byp_d = byp_q;
    if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(PRECHG_CYC - 1)) byp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      byp_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      byp_q <= byp_d;
    end
  end

  assign bypass_on = byp_q;

  a_r8_bypass_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_on |=> bypass_on);
endmodule

// File: rtl/pfc_trip_guard.sv
module pfc_trip_guard #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass_on,
  input  logic [DW-1:0] iin_meas,
  input  logic [DW-1:0] vout_meas,
  input  logic [DW-1:0] iin_limit,
  input  logic [DW-1:0] vout_limit,
  output logic          fault,
  output logic          pwm_en
);
  logic over_i, over_v;
  logic flt_q, flt_d, pwm_q, pwm_d;

  assign over_i = iin_meas > iin_limit;
  assign over_v = vout_meas > vout_limit;

  always_comb begin
    flt_d = flt_q | over_i | over_v;
    pwm_d = bypass_on & ~flt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      flt_q <= flt_d;
      pwm_q <= pwm_d;
    end
  end

  assign fault  = flt_q;
  assign pwm_en = pwm_q;

  a_r9_pwm_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |-> (bypass_on && !fault));
  a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  a_r8_pwm_after_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> $past(bypass_on));
endmodule

// File: rtl/pfc_cycle_seq.sv
module pfc_cycle_seq #(
  parameter int N_ADC      = 3,
  parameter int N_OUTER    = 3,
  parameter int DW         = 16,
  parameter int PRECHG_CYC = 5000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  output logic               adc_start,
  input  logic [N_ADC-1:0]   adc_ready,
  output logic               outer_start,
  input  logic [N_OUTER-1:0] outer_ready,
  output logic               ref_start,
  input  logic               ref_ready,
  output logic               inner_start,
  input  logic               inner_ready,
  output logic               duty_upd,
  output logic               overrun,
  input  logic [DW-1:0]      iin_meas,
  input  logic [DW-1:0]      vout_meas,
  input  logic [DW-1:0]      iin_limit,
  input  logic [DW-1:0]      vout_limit,
  output logic               bypass_on,
  output logic               pwm_en,
  output logic               fault
);
  logic in_acq, in_outer, adc_done, outer_done;

  pfc_ready_gather #(.N(N_ADC)) u_adc_gather (
    .clk(clk), .rst_n(rst_n), .en(in_acq), .rdy(adc_ready), .done(adc_done)
  );

  pfc_ready_gather #(.N(N_OUTER)) u_outer_gather (
    .clk(clk), .rst_n(rst_n), .en(in_outer), .rdy(outer_ready), .done(outer_done)
  );

  pfc_cycle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .adc_done(adc_done), .outer_done(outer_done),
    .ref_ready(ref_ready), .inner_ready(inner_ready),
    .in_acq(in_acq), .in_outer(in_outer),
    .adc_start(adc_start), .outer_start(outer_start), .ref_start(ref_start),
    .inner_start(inner_start), .duty_upd(duty_upd), .overrun(overrun)
  );

  pfc_startup #(.PRECHG_CYC(PRECHG_CYC)) u_startup (
    .clk(clk), .rst_n(rst_n), .bypass_on(bypass_on)
  );

  pfc_trip_guard #(.DW(DW)) u_guard (
    .clk(clk), .rst_n(rst_n), .bypass_on(bypass_on),
    .iin_meas(iin_meas), .vout_meas(vout_meas),
    .iin_limit(iin_limit), .vout_limit(vout_limit),
    .fault(fault), .pwm_en(pwm_en)
  );
endmodule

// File: tb/pfc_cycle_seq_bench.sv
module pfc_cycle_seq_bench;
  localparam int PRE = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic [2:0] adc_ready, outer_ready;
  logic ref_ready, inner_ready;
  logic [15:0] iin_meas, vout_meas, iin_limit, vout_limit;
  logic adc_start, outer_start, ref_start, inner_start, duty_upd, overrun;
  logic bypass_on, pwm_en, fault;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  int    q_kind[$];
  int    q_cyc[$];
  string q_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pfc_cycle_seq #(.PRECHG_CYC(PRE)) u_pfc_cycle_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .adc_start(adc_start), .adc_ready(adc_ready),
    .outer_start(outer_start), .outer_ready(outer_ready),
    .ref_start(ref_start), .ref_ready(ref_ready),
    .inner_start(inner_start), .inner_ready(inner_ready),
    .duty_upd(duty_upd), .overrun(overrun),
    .iin_meas(iin_meas), .vout_meas(vout_meas),
    .iin_limit(iin_limit), .vout_limit(vout_limit),
    .bypass_on(bypass_on), .pwm_en(pwm_en), .fault(fault)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // strobe kinds: 0 adc_start, 1 outer_start, 2 ref_start, 3 inner_start, 4 duty_upd, 5 overrun
  task automatic push(input int kind, input int at, input string tag);
    q_kind.push_back(kind);
    q_cyc.push_back(at);
    q_tag.push_back(tag);
  endtask

  // monitor: every observed strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      logic [5:0] s;
      s = {overrun, duty_upd, inner_start, ref_start, outer_start, adc_start};
      for (int k = 0; k < 6; k++) begin
        if (s[k]) begin
          if (q_kind.size() == 0) begin
            total++; bad++;
            $display("FAIL R6: actual=strobe kind %0d at cycle %0d expected=none", k, cyc);
          end else begin
            int ek, ec; string et;
            ek = q_kind.pop_front(); ec = q_cyc.pop_front(); et = q_tag.pop_front();
            check(et, k, ek);
            check(et, cyc, ec);
          end
        end
      end
    end
  end

  // drive three ready lines with per-line delays; optional busy tick / stray readies
  task automatic grp3(input int a, input int b, input int c, input bit is_adc,
                      input int nxt, input string tag, input bit busy_tick, input bit stray);
    int m;
    m = (a > b) ? a : b;
    m = (c > m) ? c : m;
    for (int t = 1; t <= m; t++) begin
      if (is_adc) adc_ready = {c == t, b == t, a == t};
      else        outer_ready = {c == t, b == t, a == t};
      if (busy_tick && t == 1) begin tick = 1'b1; push(5, cyc + 1, "R7"); end
      if (stray && t == 1) begin outer_ready = 3'b111; ref_ready = 1'b1; inner_ready = 1'b1; end
      if (t == m) push(nxt, cyc + 1, tag);
      @(negedge clk);
      tick = 1'b0; ref_ready = 1'b0; inner_ready = 1'b0;
      if (is_adc) outer_ready = 3'b000;
    end
    adc_ready = 3'b000; outer_ready = 3'b000;
  endtask

  task automatic single(input bit is_ref, input int d, input int nxt, input string tag);
    for (int t = 1; t < d; t++) @(negedge clk);
    if (is_ref) ref_ready = 1'b1; else inner_ready = 1'b1;
    push(nxt, cyc + 1, tag);
    @(negedge clk);
    ref_ready = 1'b0; inner_ready = 1'b0;
  endtask

  // starts at the current negedge, ends at the negedge where duty_upd is visible
  task automatic run_pass(input int a0, input int a1, input int a2,
                          input int o0, input int o1, input int o2,
                          input int rd, input int id, input bit busy, input bit stray);
    tick = 1'b1;
    push(0, cyc + 1, "R2");
    @(negedge clk);
    tick = 1'b0;
    grp3(a0, a1, a2, 1'b1, 1, "R3", busy, stray);
    grp3(o0, o1, o2, 1'b0, 2, "R4", 1'b0, 1'b0);
    single(1'b1, rd, 3, "R5");
    single(1'b0, id, 4, "R5");
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0;
    adc_ready = '0; outer_ready = '0; ref_ready = 1'b0; inner_ready = 1'b0;
    iin_meas = 16'd0; vout_meas = 16'd0; iin_limit = 16'd1000; vout_limit = 16'd1000;
    repeat (3) @(negedge clk);
    check("R1", {adc_start, outer_start, ref_start, inner_start, duty_upd, overrun}, 0);
    check("R1", {bypass_on, pwm_en, fault}, 0);
    rst_n = 1'b1;
    for (int e = 1; e <= PRE + 1; e++) begin
      @(negedge clk);
      if (e == PRE - 1) check("R8", bypass_on, 0);
      if (e == PRE) begin check("R8", bypass_on, 1); check("R8", pwm_en, 0); end
      if (e == PRE + 1) check("R8", pwm_en, 1);
    end

    // readies while idle: no effect
    adc_ready = 3'b111; outer_ready = 3'b111; ref_ready = 1'b1; inner_ready = 1'b1;
    @(negedge clk);
    adc_ready = '0; outer_ready = '0; ref_ready = 1'b0; inner_ready = 1'b0;
    repeat (3) @(negedge clk);

    run_pass(1, 1, 1, 1, 1, 1, 1, 1, 1'b0, 1'b0);
    run_pass(3, 1, 2, 2, 4, 1, 3, 2, 1'b0, 1'b0);   // back-to-back tick in duty_upd cycle
    repeat (2) @(negedge clk);
    run_pass(2, 5, 2, 3, 3, 3, 1, 4, 1'b1, 1'b0);   // R7 tick during acquisition
    repeat (2) @(negedge clk);
    run_pass(4, 2, 3, 1, 2, 5, 2, 1, 1'b0, 1'b1);   // R6 stray readies in acquisition
    repeat (4) @(negedge clk);
    check("R5", q_kind.size(), 0);

    // over-voltage: equality holds, above trips, trip persists
    vout_meas = 16'd1000;
    @(negedge clk); @(negedge clk);
    check("R10", fault, 0); check("R10", pwm_en, 1);
    vout_meas = 16'd1001;
    @(negedge clk);
    check("R10", fault, 1); check("R10", pwm_en, 0);
    vout_meas = 16'd0;
    repeat (5) @(negedge clk);
    check("R11", fault, 1); check("R11", pwm_en, 0); check("R11", bypass_on, 1);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {bypass_on, pwm_en, fault}, 0);
    rst_n = 1'b1;
    repeat (PRE + 2) @(negedge clk);
    check("R8", pwm_en, 1);
    iin_meas = 16'd2000;
    @(negedge clk);
    check("R9", fault, 1); check("R9", pwm_en, 0);
    iin_meas = 16'd0;
    repeat (3) @(negedge clk);
    check("R11", fault, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule